// File: doc/BRIEF.md
# Flash Block Lock-Protection Controller

This controller fronts a small block-organised nonvolatile array, here modelled in registers, in which every block carries its own lock bit. Software-side logic sends it commands over a valid/ready request channel. The commands are page program, single-block erase, erase of every unlocked block, lock-bit program, lock-status read and a write of the global protection-bypass bit. A block whose lock bit is 0 refuses program and erase unless the bypass bit is set. Setting the bypass bit never alters a stored lock bit.

Program and erase run for a fixed number of cycles, and `busy` is high while they run. A refused command raises an error flag and holds `busy` for a single cycle. An abort input stands for the interrupt sources that force the controller back to its idle state. If an abort lands during a program or erase, the targeted blocks are flagged invalid. A later successful erase of a block clears its flag.

Back-pressure rule: a command transfers on a rising edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low for as long as `busy` is high. A requester that holds `cmd_valid` with stable fields simply waits, and nothing is lost.

Top module: `flp_ctrl`

## Requirements
- R1: A command transfers only on an edge with `cmd_valid` and `cmd_ready` both high. `cmd_ready` equals the inverse of `busy`, and a command held across a busy period is taken exactly once, on the first edge after `busy` falls.
- R2: `cmd_op` codes are 0 page program, 1 block erase, 2 erase-all-unlocked, 3 lock-bit program, 4 lock-status read and 5 bypass write. Codes 6 and 7 are accepted and have no effect on memory, lock bits, bypass or `busy`.
- R3: A page program or block erase at a block whose lock bit is 0, with bypass 0, changes no memory. It sets `err_locked` and holds `busy` for exactly one cycle. `err_locked` shows whether the most recently accepted command was refused this way.
- R4: An accepted page program holds `busy` for OP_CYCLES cycles. On the edge where `busy` falls, the addressed word becomes its old value ANDed with `cmd_data`.
- R5: A block erase that is not refused sets every word of its block to all ones, sets the block's lock bit to 1 and clears its invalid flag, all when `busy` falls.
- R6: With bypass 0, erase-all erases exactly the blocks whose lock bit was 1 at acceptance. With bypass 1 it erases every block and leaves every lock bit at 1.
- R7: A lock-bit program clears the addressed block's lock bit to 0 after OP_CYCLES busy cycles. Only an erase of the block can return the bit to 1.
- R8: One edge after a lock-status read is accepted, `rsp_valid` is high for one cycle and `rsp_lock` carries the addressed block's lock bit.
- R9: A bypass write sets `bypass_o` to `cmd_data[0]`. While it is 1, every block accepts program and erase, and the stored lock bits stay as they were. Clearing the bypass bit brings back refusal using those retained bits.
- R10: On the edge after `abort_i` is high, `busy`, `bypass_o`, `err_locked` and `rsp_valid` are 0, and no pending commit happens. If a program or erase was running, the invalid flag of each targeted block is set. Memory and lock bits are otherwise kept.
- R11: After `rst_n` is asserted, every word reads all ones, every lock bit is 1, every invalid flag is 0, bypass is 0 and `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| abort_i | input | 1 | Forces the controller idle, flags interrupted blocks |
| cmd_valid | input | 1 | Command request valid |
| cmd_ready | output | 1 | Controller can take a command |
| cmd_op | input | 3 | Command code |
| cmd_blk | input | BLK_W | Target block |
| cmd_word | input | WRD_W | Target word for page program |
| cmd_data | input | DATA_W | Program data, or bypass value in bit 0 |
| busy | output | 1 | Operation in progress |
| err_locked | output | 1 | Last accepted command was refused by protection |
| rsp_valid | output | 1 | Lock-status response valid |
| rsp_lock | output | 1 | Returned lock bit |
| bypass_o | output | 1 | Current bypass bit |
| rd_blk | input | BLK_W | Array read block address |
| rd_word | input | WRD_W | Array read word address |
| rd_data | output | DATA_W | Combinational array read data |
| blk_invalid | output | NB | Per-block invalid flags |

## Verification
A lock-status answer is due one edge after acceptance. A refused program or erase shows `err_locked` at the acceptance edge and drops `busy` one edge later. A valid program, erase or lock-bit program lands exactly OP_CYCLES edges after acceptance. Abort effects appear on the edge following the abort cycle. The bench advances its behavioural model once per clock edge, using the inputs held since the previous falling edge. It then compares every output with the model at the next falling edge, so each result is sampled in the cycle it is due and never at the edge where it changes.

// File: rtl/flp_pkg.sv
package flp_pkg;
  typedef enum logic [2:0] {
    OP_PROG      = 3'd0,
    OP_ERASE     = 3'd1,
    OP_ERASE_ALL = 3'd2,
    OP_LOCK      = 3'd3,
    OP_RDLOCK    = 3'd4,
    OP_BYPASS    = 3'd5,
    OP_RSV6      = 3'd6,
    OP_RSV7      = 3'd7
  } flp_op_e;
endpackage

// File: rtl/flp_seq.sv
module flp_seq
  import flp_pkg::*;
#(
  parameter int NB        = 4,
  parameter int BLK_W     = 2,
  parameter int WRD_W     = 2,
  parameter int DATA_W    = 8,
  parameter int OP_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort_i,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [BLK_W-1:0]  cmd_blk,
  input  logic [WRD_W-1:0]  cmd_word,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic [NB-1:0]     lock_vec,
  output logic              cmd_ready,
  output logic              busy,
  output logic              err_locked,
  output logic              rsp_valid,
  output logic              rsp_lock,
  output logic              bypass,
  output logic              commit,
  output logic              kill,
  output flp_op_e           op_q,
  output logic [NB-1:0]     mask_q,
  output logic [WRD_W-1:0]  word_q,
  output logic [DATA_W-1:0] data_q
);
  localparam int CW = (OP_CYCLES < 2) ? 1 : $clog2(OP_CYCLES);
  localparam logic [CW-1:0] CNT_LAST = CW'(OP_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          rej_q;
  flp_op_e       op_d;
  logic [NB-1:0] onehot;
  logic          blocked;
  logic          runs;
  logic          accept;

  assign op_d    = flp_op_e'(cmd_op);
  assign onehot  = NB'(1) << cmd_blk;
  assign accept  = cmd_valid && !busy;
  assign blocked = ((op_d == OP_PROG) || (op_d == OP_ERASE)) &&
                   !lock_vec[cmd_blk] && !bypass;
  assign runs    = (op_d == OP_PROG) || (op_d == OP_ERASE) ||
                   (op_d == OP_ERASE_ALL) || (op_d == OP_LOCK);

  assign cmd_ready = !busy;
  assign commit    = busy && (cnt_q == '0) && !rej_q && !abort_i;
  assign kill      = abort_i && busy && !rej_q &&
                     ((op_q == OP_PROG) || (op_q == OP_ERASE) ||
                      (op_q == OP_ERASE_ALL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      cnt_q      <= '0;
      rej_q      <= 1'b0;
      err_locked <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_lock   <= 1'b0;
      bypass     <= 1'b0;
      op_q       <= OP_RSV7;
      mask_q     <= '0;
      word_q     <= '0;
      data_q     <= '0;
    end else if (abort_i) begin
      busy       <= 1'b0;
      cnt_q      <= '0;
      rej_q      <= 1'b0;
      err_locked <= 1'b0;
      rsp_valid  <= 1'b0;
      bypass     <= 1'b0;
      mask_q     <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (busy) begin
        if (cnt_q == '0) busy <= 1'b0;
        else             cnt_q <= cnt_q - 1'b1;
      end else if (accept) begin
        op_q       <= op_d;
        word_q     <= cmd_word;
        data_q     <= cmd_data;
        err_locked <= blocked;
        rej_q      <= blocked;
        busy       <= runs;
        cnt_q      <= blocked ? '0 : CNT_LAST;
        if (op_d == OP_ERASE_ALL) mask_q <= bypass ? '1 : lock_vec;
        else                      mask_q <= onehot;
        if (op_d == OP_RDLOCK) begin
          rsp_valid <= 1'b1;
          rsp_lock  <= lock_vec[cmd_blk];
        end
        if (op_d == OP_BYPASS) bypass <= cmd_data[0];
      end
    end
  end
endmodule

// File: rtl/flp_array.sv
module flp_array
  import flp_pkg::*;
#(
  parameter int NB     = 4,
  parameter int WPB    = 4,
  parameter int BLK_W  = 2,
  parameter int WRD_W  = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic              kill,
  input  flp_op_e           op_q,
  input  logic [NB-1:0]     mask_q,
  input  logic [WRD_W-1:0]  word_q,
  input  logic [DATA_W-1:0] data_q,
  input  logic [BLK_W-1:0]  rd_blk,
  input  logic [WRD_W-1:0]  rd_word,
  output logic [DATA_W-1:0] rd_data,
  output logic [NB-1:0]     blk_invalid
);
  logic [WPB-1:0][DATA_W-1:0] bank [NB];

  for (genvar gi = 0; gi < NB; gi++) begin : g_blk
    logic [WPB-1:0][DATA_W-1:0] words_q;
    logic                       inv_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        words_q <= '1;
        inv_q   <= 1'b0;
      end else if (kill && mask_q[gi]) begin
        inv_q <= 1'b1;
      end else if (commit && mask_q[gi]) begin
        case (op_q)
          OP_PROG: words_q[word_q] <= words_q[word_q] & data_q;
          OP_ERASE, OP_ERASE_ALL: begin
            words_q <= '1;
            inv_q   <= 1'b0;
          end
          default: ;
        endcase
      end
    end

    assign bank[gi]        = words_q;
    assign blk_invalid[gi] = inv_q;
  end

  assign rd_data = bank[rd_blk][rd_word];
endmodule

// File: rtl/flp_lockbits.sv
module flp_lockbits
  import flp_pkg::*;
#(
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit,
  input  flp_op_e       op_q,
  input  logic [NB-1:0] mask_q,
  output logic [NB-1:0] lock_vec
);
  for (genvar gi = 0; gi < NB; gi++) begin : g_lk
    logic lk_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lk_q <= 1'b1;
      end else if (commit && mask_q[gi]) begin
        if (op_q == OP_LOCK)                              lk_q <= 1'b0;
        else if (op_q == OP_ERASE || op_q == OP_ERASE_ALL) lk_q <= 1'b1;
      end
    end
    assign lock_vec[gi] = lk_q;
  end
endmodule

// File: rtl/flp_ctrl.sv
module flp_ctrl
  import flp_pkg::*;
#(
  parameter int NB        = 4,
  parameter int WPB       = 4,
  parameter int DATA_W    = 8,
  parameter int OP_CYCLES = 4,
  localparam int BLK_W    = (NB  < 2) ? 1 : $clog2(NB),
  localparam int WRD_W    = (WPB < 2) ? 1 : $clog2(WPB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort_i,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [BLK_W-1:0]  cmd_blk,
  input  logic [WRD_W-1:0]  cmd_word,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              busy,
  output logic              err_locked,
  output logic              rsp_valid,
  output logic              rsp_lock,
  output logic              bypass_o,
  input  logic [BLK_W-1:0]  rd_blk,
  input  logic [WRD_W-1:0]  rd_word,
  output logic [DATA_W-1:0] rd_data,
  output logic [NB-1:0]     blk_invalid
);
  logic [NB-1:0]     lock_vec;
  logic              commit;
  logic              kill;
  flp_op_e           op_q;
  logic [NB-1:0]     mask_q;
  logic [WRD_W-1:0]  word_q;
  logic [DATA_W-1:0] data_q;

  flp_seq #(
    .NB(NB), .BLK_W(BLK_W), .WRD_W(WRD_W), .DATA_W(DATA_W), .OP_CYCLES(OP_CYCLES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .abort_i(abort_i),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_blk(cmd_blk),
    .cmd_word(cmd_word), .cmd_data(cmd_data), .lock_vec(lock_vec),
    .cmd_ready(cmd_ready), .busy(busy), .err_locked(err_locked),
    .rsp_valid(rsp_valid), .rsp_lock(rsp_lock), .bypass(bypass_o),
    .commit(commit), .kill(kill), .op_q(op_q), .mask_q(mask_q),
    .word_q(word_q), .data_q(data_q)
  );

  flp_array #(
    .NB(NB), .WPB(WPB), .BLK_W(BLK_W), .WRD_W(WRD_W), .DATA_W(DATA_W)
  ) u_array (
    .clk(clk), .rst_n(rst_n), .commit(commit), .kill(kill), .op_q(op_q),
    .mask_q(mask_q), .word_q(word_q), .data_q(data_q),
    .rd_blk(rd_blk), .rd_word(rd_word), .rd_data(rd_data),
    .blk_invalid(blk_invalid)
  );

  flp_lockbits #(.NB(NB)) u_lock (
    .clk(clk), .rst_n(rst_n), .commit(commit), .op_q(op_q),
    .mask_q(mask_q), .lock_vec(lock_vec)
  );
endmodule

// File: rtl/flp_ctrl_chk.sv
module flp_ctrl_chk
  import flp_pkg::*;
#(
  parameter int NB    = 4,
  parameter int BLK_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             abort_i,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [2:0]       cmd_op,
  input logic [BLK_W-1:0] cmd_blk,
  input logic             busy,
  input logic             err_locked,
  input logic             rsp_valid,
  input logic             rsp_lock,
  input logic             bypass_o,
  input logic [NB-1:0]    blk_invalid,
  input logic [NB-1:0]    lock_vec,
  input logic             commit,
  input flp_op_e          op_q
);
  // R3: protected target refused with error and a busy cycle
  a_r3_refuse_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !abort_i && (cmd_op == 3'd0 || cmd_op == 3'd1) &&
     !lock_vec[cmd_blk] && !bypass_o) |=> (err_locked && busy));

  // R7: a lock bit rises only through an erase commit
  a_r7_lock_rise_by_erase: assert property (@(posedge clk) disable iff (!rst_n)
    (|(lock_vec & ~$past(lock_vec))) |->
      $past(commit && (op_q == OP_ERASE || op_q == OP_ERASE_ALL)));

  // R8: lock-status answer one edge after acceptance
  a_r8_lock_answer: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !abort_i && cmd_op == 3'd4) |=>
      (rsp_valid && rsp_lock == $past(lock_vec[cmd_blk])));

  // R10: abort returns control state to idle
  a_r10_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (!busy && !bypass_o && !err_locked && !rsp_valid));

  // R10: invalid flags appear only after an abort
  a_r10_invalid_by_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (|(blk_invalid & ~$past(blk_invalid))) |-> $past(abort_i));
endmodule

bind flp_ctrl flp_ctrl_chk #(.NB(NB), .BLK_W(BLK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .abort_i(abort_i), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_blk(cmd_blk), .busy(busy),
  .err_locked(err_locked), .rsp_valid(rsp_valid), .rsp_lock(rsp_lock),
  .bypass_o(bypass_o), .blk_invalid(blk_invalid), .lock_vec(lock_vec),
  .commit(commit), .op_q(op_q)
);

// File: tb/flp_ctrl_tb_top.sv
module flp_ctrl_tb_top;
  localparam int NB = 4, WPB = 4, DW = 8, OPC = 4, BW = 2, WW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic abort_i = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [2:0] cmd_op = '0;
  logic [BW-1:0] cmd_blk = '0;
  logic [WW-1:0] cmd_word = '0;
  logic [DW-1:0] cmd_data = '0;
  logic busy, err_locked, rsp_valid, rsp_lock, bypass_o;
  logic [BW-1:0] rd_blk = '0;
  logic [WW-1:0] rd_word = '0;
  logic [DW-1:0] rd_data;
  logic [NB-1:0] blk_invalid;

  int checks = 0;
  int errors = 0;
  bit rd_hold = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  flp_ctrl #(.NB(NB), .WPB(WPB), .DATA_W(DW), .OP_CYCLES(OPC)) dut_i (
    .clk(clk), .rst_n(rst_n), .abort_i(abort_i), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_blk(cmd_blk),
    .cmd_word(cmd_word), .cmd_data(cmd_data), .busy(busy),
    .err_locked(err_locked), .rsp_valid(rsp_valid), .rsp_lock(rsp_lock),
    .bypass_o(bypass_o), .rd_blk(rd_blk), .rd_word(rd_word),
    .rd_data(rd_data), .blk_invalid(blk_invalid)
  );

  // behavioural reference model
  logic [DW-1:0] m_mem [NB][WPB];
  bit m_lock [NB];
  bit m_inv [NB];
  bit m_mask [NB];
  bit m_busy, m_rej, m_byp, m_err, m_rv, m_rl, m_acc;
  int m_cnt, m_op, m_word;
  logic [DW-1:0] m_data;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_init();
    for (int b = 0; b < NB; b++) begin
      for (int w = 0; w < WPB; w++) m_mem[b][w] = '1;
      m_lock[b] = 1; m_inv[b] = 0; m_mask[b] = 0;
    end
    m_busy = 0; m_rej = 0; m_byp = 0; m_err = 0; m_rv = 0; m_rl = 0;
    m_cnt = 0; m_op = 7; m_word = 0; m_data = '0;
  endtask

  task automatic model_commit();
    for (int b = 0; b < NB; b++) begin
      if (m_mask[b]) begin
        if (m_op == 0) m_mem[b][m_word] = m_mem[b][m_word] & m_data;
        else if (m_op == 1 || m_op == 2) begin
          for (int w = 0; w < WPB; w++) m_mem[b][w] = '1;
          m_lock[b] = 1; m_inv[b] = 0;
        end else if (m_op == 3) m_lock[b] = 0;
      end
    end
  endtask

  task automatic model_step();
    bit blocked;
    m_acc = 0;
    if (abort_i) begin
      if (m_busy && !m_rej && m_op <= 2)
        for (int b = 0; b < NB; b++) if (m_mask[b]) m_inv[b] = 1;
      m_busy = 0; m_cnt = 0; m_rej = 0; m_byp = 0; m_err = 0; m_rv = 0;
      for (int b = 0; b < NB; b++) m_mask[b] = 0;
      return;
    end
    m_rv = 0;
    if (m_busy) begin
      if (m_cnt == 0) begin
        if (!m_rej) model_commit();
        m_busy = 0;
      end else m_cnt--;
    end else if (cmd_valid) begin
      m_acc = 1;
      blocked = (cmd_op <= 1) && !m_lock[cmd_blk] && !m_byp;
      m_err = blocked; m_rej = blocked;
      m_op = cmd_op; m_word = cmd_word; m_data = cmd_data;
      for (int b = 0; b < NB; b++)
        m_mask[b] = (cmd_op == 2) ? (m_byp || m_lock[b]) : (b == cmd_blk);
      m_busy = (cmd_op <= 3);
      m_cnt = blocked ? 0 : OPC - 1;
      if (cmd_op == 4) begin m_rv = 1; m_rl = m_lock[cmd_blk]; end
      if (cmd_op == 5) m_byp = cmd_data[0];
    end
  endtask

  task automatic compare_all();
    logic [NB-1:0] inv_v;
    for (int b = 0; b < NB; b++) inv_v[b] = m_inv[b];
    chk(busy == m_busy, "R4 busy", busy, m_busy);
    chk(cmd_ready == !m_busy, "R1 cmd_ready", cmd_ready, !m_busy);
    chk(err_locked == m_err, "R3 err_locked", err_locked, m_err);
    chk(rsp_valid == m_rv, "R8 rsp_valid", rsp_valid, m_rv);
    if (m_rv) chk(rsp_lock == m_rl, "R8 rsp_lock", rsp_lock, m_rl);
    chk(bypass_o == m_byp, "R9 bypass", bypass_o, m_byp);
    chk(blk_invalid == inv_v, "R10 invalid", blk_invalid, inv_v);
    chk(rd_data == m_mem[rd_blk][rd_word], "R4 rd_data", rd_data,
        m_mem[rd_blk][rd_word]);
  endtask

  task automatic step();
    model_step();
    @(negedge clk);
    compare_all();
    if (!rd_hold) {rd_blk, rd_word} = {rd_blk, rd_word} + 1'b1;
  endtask

  task automatic issue(int op, int blk, int word, int data);
    cmd_valid = 1; cmd_op = 3'(op); cmd_blk = BW'(blk);
    cmd_word = WW'(word); cmd_data = DW'(data);
    do step(); while (!m_acc);
    cmd_valid = 0;
  endtask

  task automatic settle();
    while (m_busy) step();
    step();
  endtask

  task automatic expect_word(int blk, int word, int exp, string tag);
    rd_hold = 1; rd_blk = BW'(blk); rd_word = WW'(word);
    step();
    chk(rd_data == DW'(exp), tag, rd_data, exp);
    rd_hold = 0;
  endtask

  task automatic expect_lock(int blk, bit exp, string tag);
    issue(4, blk, 0, 0);
    chk(rsp_valid && rsp_lock == exp, tag, rsp_lock, exp);
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_init();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !bypass_o && blk_invalid == '0, "R11 reset flags", busy, 0);
    chk(rd_data == 8'hFF, "R11 reset word", rd_data, 8'hFF);
    step();
    expect_lock(0, 1, "R11 reset lock");
    // page program ANDs
    issue(0, 0, 1, 8'h5A); settle();
    expect_word(0, 1, 8'h5A, "R4 program");
    issue(0, 0, 1, 8'h0F); settle();
    expect_word(0, 1, 8'h0A, "R4 and-merge");
    // lock program, refusals
    issue(3, 1, 0, 0); settle();
    expect_lock(1, 0, "R7 lock cleared");
    issue(0, 1, 0, 8'h00); settle();
    chk(err_locked == 1, "R3 prog refused err", err_locked, 1);
    expect_word(1, 0, 8'hFF, "R3 prog refused word");
    issue(1, 1, 0, 0); settle();
    chk(err_locked == 1, "R3 erase refused err", err_locked, 1);
    expect_lock(1, 0, "R7 lock kept after refused erase");
    // erase-all skipping locked block
    issue(0, 2, 3, 8'h00); settle();
    issue(2, 0, 0, 0); settle();
    expect_word(2, 3, 8'hFF, "R6 erase-all unlocked");
    expect_word(0, 1, 8'hFF, "R6 erase-all block0");
    expect_lock(1, 0, "R6 locked block skipped");
    // bypass
    issue(5, 0, 0, 1); settle();
    issue(0, 1, 2, 8'h33); settle();
    expect_word(1, 2, 8'h33, "R9 bypass program");
    expect_lock(1, 0, "R9 lock retained");
    issue(5, 0, 0, 0); settle();
    issue(0, 1, 2, 8'h00); settle();
    chk(err_locked == 1, "R9 protection restored", err_locked, 1);
    expect_word(1, 2, 8'h33, "R9 word unchanged");
    issue(5, 0, 0, 1); settle();
    issue(2, 0, 0, 0); settle();
    expect_word(1, 2, 8'hFF, "R6 bypass erase-all");
    expect_lock(1, 1, "R5 erase sets lock");
    issue(5, 0, 0, 0); settle();
    // back-pressure: second command held while busy
    issue(0, 3, 0, 8'hF0);
    issue(0, 3, 0, 8'h3C); settle();
    expect_word(3, 0, 8'h30, "R1 held command");
    // reserved code
    issue(6, 3, 0, 8'h00); step();
    chk(!busy, "R2 reserved no busy", busy, 0);
    expect_word(3, 0, 8'h30, "R2 reserved no effect");
    // abort during program with bypass set
    issue(5, 0, 0, 1); settle();
    issue(0, 0, 0, 8'h00); step(); step();
    abort_i = 1; step(); abort_i = 0;
    chk(!bypass_o && !busy, "R10 abort idle", bypass_o, 0);
    chk(blk_invalid == 4'b0001, "R10 abort invalid", blk_invalid, 4'b0001);
    expect_word(0, 0, 8'hFF, "R10 no commit");
    issue(1, 0, 0, 0); settle();
    chk(blk_invalid == 4'b0000, "R5 erase clears invalid", blk_invalid, 0);
    // abort during erase-all with block3 locked
    issue(3, 3, 0, 0); settle();
    issue(2, 0, 0, 0); step();
    abort_i = 1; step(); abort_i = 0;
    step();
    chk(blk_invalid == 4'b0111, "R10 erase-all abort", blk_invalid, 4'b0111);
    expect_lock(3, 0, "R10 lock kept");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule